// File: doc/BRIEF.md
# Source-Routed Packet Steering Node

This block is a one-input, two-output switch for packets made of one-of-five symbols. Each symbol is carried on five wires, at most one of them high, and moves over a four-phase handshake. The sender raises one wire. The receiver raises its acknowledge. The sender returns the wires to zero. The receiver then drops its acknowledge. Here the handshake is modelled synchronously: every wire is a signal sampled on a common clock.

A packet starts with a route symbol. That symbol is followed by any number of body symbols and then by an end-of-packet symbol. The node consumes the leading symbol itself and does not pass it on. It uses that symbol to pick output x or output y, and forwards every later symbol unchanged to that output. The end-of-packet symbol is also forwarded, and after it is delivered the route is cleared, so the next symbol that arrives is treated as a fresh route symbol. A route symbol that names no output raises an error flag, and the node then discards the packet up to and including its end of packet.

The input is acknowledged only after the selected output has acknowledged the copy, so back-pressure from either output reaches the sender directly.

Top module: `steer_node`

## Requirements
- R1: While reset is held and immediately after it is released, in_ack, route_err, x_sym and y_sym are all zero.
- R2: When no route is set, the next symbol is consumed as the route symbol. in_ack rises on the clock after it is presented, and neither output carries it.
- R3: A route symbol on wire 0 (in_sym bit 0) selects output x. Each later symbol appears on x_sym one clock after it is presented, and y_sym stays zero.
- R4: A route symbol on wire 1 (in_sym bit 1) selects output y. Each later symbol appears on y_sym one clock after it is presented, and x_sym stays zero.
- R5: Body symbols of any data value, wires 0 to 3, are forwarded bit for bit and are not decoded again as routes.
- R6: The end-of-packet symbol (in_sym bit 4) is forwarded to the selected output. After it is acknowledged the route is cleared, and the next symbol is taken as a new route symbol.
- R7: A route symbol on wire 2 or wire 3 raises route_err together with in_ack. All later symbols, up to and including end of packet, are acknowledged without reaching either output. route_err falls when that end of packet is acknowledged.
- R8: An end-of-packet symbol that arrives with no route set is acknowledged and dropped, and no route is set by it.
- R9: While a forwarded symbol is waiting for its output acknowledge, in_ack stays low. in_ack rises on the clock after the selected acknowledge is seen.
- R10: A forwarded symbol stays stable on its output until acknowledged, and returns to zero on the same clock that in_ack rises.
- R11: in_ack stays high while in_sym is nonzero and falls on the clock after in_sym returns to zero.
- R12: Each output carries at most one high wire, and the two outputs are never active at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_sym | input | 5 | Incoming symbol wires: bits 0 to 3 carry data, bit 4 marks end of packet |
| in_ack | output | 1 | Acknowledge back to the sender |
| x_sym | output | 5 | Symbol wires toward output x |
| x_ack | input | 1 | Acknowledge from output x |
| y_sym | output | 5 | Symbol wires toward output y |
| y_ack | input | 1 | Acknowledge from output y |
| route_err | output | 1 | High while a packet with an invalid route symbol is being discarded |

## Verification
The node has no tunable parameters: the five-wire symbol and the two outputs are fixed. The bench therefore sweeps the whole space of packet shapes. It sends every route symbol value, end of packet included, each with body lengths from zero to three. The body data values rotate through all four data wires, so each output receives values that would also be valid routes. The output-side stall also varies from zero to two clocks. Back-to-back packets show that each end of packet rearms route decoding, and that an end of packet arriving with no route is dropped without leaving any state behind.

// File: rtl/steer_pkg.sv
package steer_pkg;
  localparam int SYM_W   = 5;
  localparam int EOP_BIT = SYM_W - 1;
  localparam int X_WIRE  = 0;
  localparam int Y_WIRE  = 1;
  localparam int N_PORTS = 2;

  typedef logic [SYM_W-1:0] sym_t;

  typedef enum logic [1:0] {RT_NONE, RT_X, RT_Y, RT_DROP} route_e;
  typedef enum logic [1:0] {PH_WAIT, PH_SEND, PH_ACK} phase_e;
endpackage

// File: rtl/steer_route_dec.sv
module steer_route_dec
  import steer_pkg::*;
(
  input  sym_t   sym_i,
  output route_e route_o
);
  always_comb begin
    if (sym_i == '0 || sym_i[EOP_BIT])
      route_o = RT_NONE;
    else if (sym_i[X_WIRE])
      route_o = RT_X;
    else if (sym_i[Y_WIRE])
      route_o = RT_Y;
    else
      route_o = RT_DROP;
  end
endmodule

// File: rtl/steer_fsm.sv
module steer_fsm
  import steer_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  sym_t   in_sym,
  input  route_e dec_route,
  input  logic   sel_ack,
  output route_e route_q,
  output phase_e phase_q,
  output sym_t   hold_q
);
  route_e route_d;
  phase_e phase_d;
  logic   load_hold;
  logic   in_valid;

  assign in_valid = (in_sym != '0);

  always_comb begin
    route_d   = route_q;
    phase_d   = phase_q;
    load_hold = 1'b0;
    case (phase_q)
      PH_WAIT: begin
        if (in_valid) begin
          case (route_q)
            RT_NONE: begin
              route_d = dec_route;
              phase_d = PH_ACK;
            end
            RT_DROP: begin
              if (in_sym[EOP_BIT]) route_d = RT_NONE;
              phase_d = PH_ACK;
            end
            default: begin
              if (!sel_ack) begin
                load_hold = 1'b1;
                phase_d   = PH_SEND;
              end
            end
          endcase
        end
      end
      PH_SEND: begin
        if (sel_ack) begin
          phase_d = PH_ACK;
          if (hold_q[EOP_BIT]) route_d = RT_NONE;
        end
      end
      PH_ACK: begin
        if (!in_valid) phase_d = PH_WAIT;
      end
      default: phase_d = PH_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q <= RT_NONE;
      phase_q <= PH_WAIT;
    end else begin
      route_q <= route_d;
      phase_q <= phase_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      hold_q <= '0;
    else if (load_hold)
      hold_q <= in_sym;
  end
endmodule

// File: rtl/steer_out.sv
module steer_out
  import steer_pkg::*;
#(
  parameter route_e PORT_RT = RT_X
) (
  input  route_e route_q,
  input  phase_e phase_q,
  input  sym_t   hold_q,
  output sym_t   sym_o
);
  assign sym_o = (phase_q == PH_SEND && route_q == PORT_RT) ? hold_q : '0;
endmodule

// File: rtl/steer_node.sv
module steer_node
  import steer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SYM_W-1:0] in_sym,
  output logic             in_ack,
  output logic [SYM_W-1:0] x_sym,
  input  logic             x_ack,
  output logic [SYM_W-1:0] y_sym,
  input  logic             y_ack,
  output logic             route_err
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  route_e     dec_route;
  route_e     route_q;
  phase_e     phase_q;
  sym_t       hold_q;
  logic       sel_ack;
  sym_t       port_sym [N_PORTS];
  logic       port_ack [N_PORTS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  steer_route_dec u_dec (
    .sym_i   (in_sym),
    .route_o (dec_route)
  );

  assign port_ack[0] = x_ack;
  assign port_ack[1] = y_ack;

  always_comb begin
    case (route_q)
      RT_X:    sel_ack = port_ack[0];
      RT_Y:    sel_ack = port_ack[1];
      default: sel_ack = 1'b0;
    endcase
  end

  steer_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .in_sym    (in_sym),
    .dec_route (dec_route),
    .sel_ack   (sel_ack),
    .route_q   (route_q),
    .phase_q   (phase_q),
    .hold_q    (hold_q)
  );

  for (genvar gi = 0; gi < N_PORTS; gi++) begin : g_port
    localparam route_e PRT = (gi == 0) ? RT_X : RT_Y;
    steer_out #(.PORT_RT(PRT)) u_out (
      .route_q (route_q),
      .phase_q (phase_q),
      .hold_q  (hold_q),
      .sym_o   (port_sym[gi])
    );
  end

  assign x_sym     = port_sym[0];
  assign y_sym     = port_sym[1];
  assign in_ack    = (phase_q == PH_ACK);
  assign route_err = (route_q == RT_DROP);
endmodule

// File: rtl/steer_node_chk.sv
module steer_node_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] in_sym,
  input logic       in_ack,
  input logic [4:0] x_sym,
  input logic       x_ack,
  input logic [4:0] y_sym,
  input logic       y_ack,
  input logic       route_err
);
  assert_x_backpress_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (x_sym != 5'd0 && !x_ack) |=> !in_ack);
  assert_y_backpress_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (y_sym != 5'd0 && !y_ack) |=> !in_ack);
  assert_x_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (x_sym != 5'd0 && !x_ack) |=> $stable(x_sym));
  assert_y_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (y_sym != 5'd0 && !y_ack) |=> $stable(y_sym));
  assert_ack_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ack && in_sym != 5'd0) |=> in_ack);
  assert_x_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(x_sym));
  assert_y_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(y_sym));
  assert_one_port_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(x_sym != 5'd0 && y_sym != 5'd0));
  assert_err_with_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(route_err) |-> in_ack);
  assert_err_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    route_err |-> (x_sym == 5'd0 && y_sym == 5'd0));
endmodule

bind steer_node steer_node_chk u_chk (.*);

// File: tb/sim_steer_node.sv
module sim_steer_node;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] in_sym;
  logic       in_ack;
  logic [4:0] x_sym;
  logic       x_ack;
  logic [4:0] y_sym;
  logic       y_ack;
  logic       route_err;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  steer_node u0 (
    .clk(clk), .rst_n(rst_n), .in_sym(in_sym), .in_ack(in_ack),
    .x_sym(x_sym), .x_ack(x_ack), .y_sym(y_sym), .y_ack(y_ack),
    .route_err(route_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // Consumed symbol: acknowledged, never forwarded
  task automatic send_consumed(input logic [4:0] s, input bit exp_err, input string req);
    in_sym = s;
    @(negedge clk);
    chk(in_ack == 1'b1, {req, " ack"}, in_ack, 1);
    chk(x_sym == 5'd0 && y_sym == 5'd0, {req, " no forward"}, {x_sym, y_sym}, 0);
    chk(route_err == exp_err, {req, " err"}, route_err, exp_err);
    in_sym = 5'd0;
    @(negedge clk);
    chk(in_ack == 1'b0, "R11 ack release", in_ack, 0);
  endtask

  // Forwarded symbol to port p (0 = x, 1 = y) with stall clocks
  task automatic send_fwd(input logic [4:0] s, input int p, input int stall, input string req);
    logic [4:0] sel, oth;
    in_sym = s;
    @(negedge clk);
    sel = (p == 0) ? x_sym : y_sym;
    oth = (p == 0) ? y_sym : x_sym;
    chk(sel == s, {req, " forwarded"}, sel, s);
    chk(oth == 5'd0, {req, " other port idle"}, oth, 0);
    chk(in_ack == 1'b0, "R9 no early ack", in_ack, 0);
    for (int k = 0; k < stall; k++) begin
      @(negedge clk);
      sel = (p == 0) ? x_sym : y_sym;
      chk(sel == s, "R10 held while stalled", sel, s);
      chk(in_ack == 1'b0, "R9 stall holds ack", in_ack, 0);
    end
    if (p == 0) x_ack = 1'b1; else y_ack = 1'b1;
    @(negedge clk);
    sel = (p == 0) ? x_sym : y_sym;
    chk(in_ack == 1'b1, "R9 ack after output ack", in_ack, 1);
    chk(sel == 5'd0, "R10 return to zero", sel, 0);
    in_sym = 5'd0;
    x_ack  = 1'b0;
    y_ack  = 1'b0;
    @(negedge clk);
    chk(in_ack == 1'b0, "R11 ack release", in_ack, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 50000 && !done) begin
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
        summary();
      end
    end
  end

  initial begin
    rst_n  = 1'b0;
    in_sym = 5'd0;
    x_ack  = 1'b0;
    y_ack  = 1'b0;
    repeat (3) @(negedge clk);
    chk(in_ack == 0 && route_err == 0 && x_sym == 0 && y_sym == 0, "R1 reset", {in_ack, route_err, x_sym, y_sym}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(in_ack == 0 && route_err == 0 && x_sym == 0 && y_sym == 0, "R1 after release", {in_ack, route_err, x_sym, y_sym}, 0);

    // Sweep: route wire r (0..3 data, 4 = end of packet), body length 0..3
    for (int r = 0; r < 5; r++) begin
      for (int len = 0; len < 4; len++) begin
        logic [4:0] rs;
        rs = 5'd1 << r;
        if (r == 4) begin
          send_consumed(rs, 1'b0, "R8 stray eop");
          continue;
        end
        send_consumed(rs, (r >= 2), (r == 0) ? "R2 R3 route x" : (r == 1) ? "R2 R4 route y" : "R7 bad route");
        for (int i = 0; i < len; i++) begin
          logic [4:0] b;
          b = 5'd1 << ((i + r + len) % 4);
          if (r < 2) send_fwd(b, r, (i + len) % 3, (r == 0) ? "R3 R5 body x" : "R4 R5 body y");
          else       send_consumed(b, 1'b1, "R7 discard body");
        end
        if (r < 2) send_fwd(5'b10000, r, len % 3, "R6 eop forwarded");
        else       send_consumed(5'b10000, 1'b0, "R7 discard eop");
        chk(route_err == 1'b0, "R6 route cleared", route_err, 0);
      end
    end

    // Stray end of packet then a routed packet: eop must leave no route
    send_consumed(5'b10000, 1'b0, "R8 stray eop idle");
    send_consumed(5'b00010, 1'b0, "R8 R2 route after stray");
    send_fwd(5'b00001, 1, 1, "R8 R4 y after stray");
    send_fwd(5'b10000, 1, 0, "R6 eop y");
    send_consumed(5'b00001, 1'b0, "R6 new route x");
    send_fwd(5'b00010, 0, 2, "R5 R12 y-code on x");
    send_fwd(5'b10000, 0, 0, "R6 eop x");

    done = 1'b1;
    summary();
  end
endmodule